// File: doc/BRIEF.md
# Boot-Window Command Interpreter

This block sits behind the write port of a NAND-style flash device's register space. It watches for writes that land in two narrow address windows of the boot buffer. A write there is read as a boot command, not as data. Three commands are understood. A warm reset clears the address registers. A two-write load sequence sends a page-load request to an external array engine. A read-identification command stores the device's identification bytes in the first three boot-buffer words.

The block also holds the block-address and page-address registers that the load uses, at two register offsets of their own. Each page load advances the page register by one page of four sectors, so a host can stream pages by repeating the load sequence. The host must watch a stall output. While a load waits for its acknowledge, or while the identification words are being written, every write on the port is dropped.

Top module: `boot_cmd_ctrl`

## Requirements
- R1: After rst_n is sampled low, every output is zero: no load request, no boot-buffer write, no stall, no warm-reset pulse, no unknown-command flag, not armed, block and page registers at 0.
- R2: Only accepted writes with wr_addr in 0x0000–0x01FF or 0x8000–0x800F are decoded as boot commands. A command value written at any other address (for example 0x0200 or 0x8010) has no effect.
- R3: A first-cycle window write of 0x00F0 gives a one-cycle warm_rst pulse in the cycle after the write. It also clears the block register, the page register and the armed state at that same edge.
- R4: A first-cycle window write of 0x00E0 sets load_armed. The next accepted window write is consumed as the second cycle whatever its value, and it clears load_armed. A consumed value is never decoded as a command, so 0x00F0 there gives no warm reset.
- R5: A consumed second-cycle value of 0x0000 raises load_req in the next cycle. load_sector is {block number, page[7:0]}. The block number is block register bits 11:0, ORed with the density mask (0x1000 by default) when block register bit 15 is set; bits 14:12 are ignored. load_req and load_sector hold until load_ack is sampled high.
- R6: When load_ack is sampled high while load_req is high, load_req drops. At the same edge the page register becomes (page + 4) mod 256.
- R7: A first-cycle window write of 0x0090 gives three boot-buffer writes on the three cycles that follow. They go to index 0, 1 and 2, with data {8'h00, manuf_id[7:0]}, {8'h00, device_id[7:0]} and {8'h00, wp_state[7:0]}.
- R8: Any other first-cycle window value does nothing else and sets unk_cmd. unk_cmd stays set until rst_n.
- R9: wr_stall is high while a load request is pending or identification words are being written. Any write made while wr_stall is high is ignored.
- R10: An accepted write at BLK_OFS (0xC010) loads the 16-bit block register. An accepted write at PG_OFS (0xC011) loads wr_data[7:0] into the page register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 16 | Word address of the write |
| wr_data | input | 16 | Write data |
| wr_stall | output | 1 | Writes are ignored while high |
| manuf_id | input | 16 | Manufacturer identification value |
| device_id | input | 16 | Device identification value |
| wp_state | input | 16 | Write-protection status value |
| load_req | output | 1 | Page-load request to the array engine |
| load_sector | output | 21 | First sector of the requested page |
| load_ack | input | 1 | Array engine accepts the request |
| bbuf_we | output | 1 | Boot-buffer write strobe |
| bbuf_idx | output | 2 | Boot-buffer word index |
| bbuf_wdata | output | 16 | Boot-buffer write data |
| warm_rst | output | 1 | One-cycle warm-reset pulse |
| unk_cmd | output | 1 | Sticky unknown-command flag |
| load_armed | output | 1 | First load cycle seen, waiting for the second |
| cur_block | output | 16 | Block-address register |
| cur_page | output | 8 | Page-address register |

## Verification
A wrong armed state shows up on the first window write after it. That write either starts a command it should have swallowed, or is swallowed when it should have started one. The difference appears on load_req, warm_rst, bbuf_we or unk_cmd one cycle later. A wrong page step or a wrong density-mask merge shows up on cur_page right at the acknowledge edge, and in load_sector of the next request. The reference model is compared against every output on every clock, so any of these shows within a cycle of the edge that caused it.

// File: rtl/boot_cmd_pkg.sv
// Shared command codes and the decoded-command type for the boot-window
// interpreter. Assumes a 16-bit data path for the code values.
package boot_cmd_pkg;
    localparam logic [15:0] CODE_WARM  = 16'h00F0;
    localparam logic [15:0] CODE_ARM   = 16'h00E0;
    localparam logic [15:0] CODE_IDENT = 16'h0090;

    typedef enum logic [1:0] {
        BC_WARM,
        BC_ARM,
        BC_IDENT,
        BC_UNKNOWN
    } boot_cmd_e;
endpackage

// File: rtl/boot_win_decode.sv
// Combinational address and value decoder.
// Works out whether a write falls in one of the two boot windows or hits an
// address register, and classifies the value as a first-cycle command.
// Assumes the windows do not overlap the register offsets.
module boot_win_decode
    import boot_cmd_pkg::*;
#(
    parameter int unsigned     ADDR_W   = 16,
    parameter int unsigned     DATA_W   = 16,
    parameter logic [ADDR_W-1:0] WA_HI  = 16'h01FF,
    parameter logic [ADDR_W-1:0] WB_LO  = 16'h8000,
    parameter logic [ADDR_W-1:0] WB_HI  = 16'h800F,
    parameter logic [ADDR_W-1:0] BLK_OFS = 16'hC010,
    parameter logic [ADDR_W-1:0] PG_OFS  = 16'hC011
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              in_win,
    output logic              is_blk,
    output logic              is_pg,
    output logic              data_zero,
    output boot_cmd_e         cmd
);
    // Address classification.
    always_comb begin
        in_win = (addr <= WA_HI) || ((addr >= WB_LO) && (addr <= WB_HI));
        is_blk = (addr == BLK_OFS);
        is_pg  = (addr == PG_OFS);
    end

    // Value classification for a first-cycle write.
    always_comb begin
        data_zero = (data == '0);
        if (data == DATA_W'(CODE_WARM))       cmd = BC_WARM;
        else if (data == DATA_W'(CODE_ARM))   cmd = BC_ARM;
        else if (data == DATA_W'(CODE_IDENT)) cmd = BC_IDENT;
        else                                  cmd = BC_UNKNOWN;
    end
endmodule

// File: rtl/boot_addr_regs.sv
// Block- and page-address registers, with the page step after a load and the
// sector index built from both. Assumes blk_we, pg_we and step never
// coincide; the top enforces this through its stall.
module boot_addr_regs #(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned BLK_FIELD_W = 12,
    parameter int unsigned BLK_W       = 13,
    parameter logic [BLK_W-1:0] DENS_MASK = 13'h1000,
    parameter int unsigned PG_W        = 8,
    parameter int unsigned PG_STEP     = 4,
    localparam int unsigned SEC_W      = BLK_W + PG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              blk_we,
    input  logic              pg_we,
    input  logic              step,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] block,
    output logic [PG_W-1:0]   page,
    output logic [SEC_W-1:0]  sector
);
    logic [BLK_W-1:0] blk_num;

    // Register update: reset, warm clear, host writes, page step.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            block <= '0;
            page  <= '0;
        end else begin
            if (blk_we) block <= wdata;
            if (pg_we)  page  <= wdata[PG_W-1:0];
            if (step)   page  <= page + PG_W'(PG_STEP);
        end
    end

    // Sector index: merged block number above the full page field.
    always_comb begin
        blk_num = BLK_W'(block[BLK_FIELD_W-1:0]);
        if (block[DATA_W-1]) blk_num = blk_num | DENS_MASK;
        sector = {blk_num, page};
    end
endmodule

// File: rtl/boot_id_seq.sv
// Writes the three identification words into boot-buffer indexes 0..2, one
// per cycle, starting the cycle after start. Each word is the low byte of
// its source with the high byte zeroed. Assumes start only while idle.
module boot_id_seq #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned N_WORDS = 3,
    localparam int unsigned IDX_W = $clog2(N_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] man,
    input  logic [DATA_W-1:0] dev,
    input  logic [DATA_W-1:0] wps,
    output logic              busy,
    output logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] wdata
);
    // Word counter: runs 0..N_WORDS-1 while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            idx  <= '0;
        end else if (busy) begin
            if (idx == IDX_W'(N_WORDS - 1)) begin
                busy <= 1'b0;
                idx  <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    // Data select: low byte of the source picked by the index.
    always_comb begin
        wdata = '0;
        case (idx)
            IDX_W'(0): wdata[7:0] = man[7:0];
            IDX_W'(1): wdata[7:0] = dev[7:0];
            default:   wdata[7:0] = wps[7:0];
        endcase
    end
endmodule

// File: rtl/boot_cmd_ctrl.sv
// Boot-window command interpreter (top).
// Decodes window writes into warm reset, the two-write page load and the
// identification store. Holds a load request until it is acknowledged and
// stalls the write port during loads and identification writes.
// Assumes the host honours wr_stall; writes made while it is high are dropped.
module boot_cmd_ctrl
    import boot_cmd_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned BLK_FIELD_W = 12,
    parameter int unsigned BLK_W       = 13,
    parameter logic [BLK_W-1:0] DENS_MASK = 13'h1000,
    parameter logic [ADDR_W-1:0] BLK_OFS = 16'hC010,
    parameter logic [ADDR_W-1:0] PG_OFS  = 16'hC011,
    localparam int unsigned PG_W       = 8,
    localparam int unsigned SEC_W      = BLK_W + PG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_stall,
    input  logic [DATA_W-1:0] manuf_id,
    input  logic [DATA_W-1:0] device_id,
    input  logic [DATA_W-1:0] wp_state,
    output logic              load_req,
    output logic [SEC_W-1:0]  load_sector,
    input  logic              load_ack,
    output logic              bbuf_we,
    output logic [1:0]        bbuf_idx,
    output logic [DATA_W-1:0] bbuf_wdata,
    output logic              warm_rst,
    output logic              unk_cmd,
    output logic              load_armed,
    output logic [DATA_W-1:0] cur_block,
    output logic [PG_W-1:0]   cur_page
);
    logic             accept, in_win, is_blk, is_pg, data_zero;
    boot_cmd_e        cmd;
    logic             first_cyc, do_warm, do_arm, do_ident, do_unk, do_load;
    logic             id_busy, step;
    logic [1:0]       id_idx;
    logic [SEC_W-1:0] sector;

    boot_win_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .BLK_OFS(BLK_OFS), .PG_OFS(PG_OFS)
    ) u_dec (
        .addr(wr_addr), .data(wr_data), .in_win(in_win), .is_blk(is_blk),
        .is_pg(is_pg), .data_zero(data_zero), .cmd(cmd)
    );

    // Write acceptance and command qualification.
    always_comb begin
        accept    = wr_en && !wr_stall;
        first_cyc = accept && in_win && !load_armed;
        do_warm   = first_cyc && (cmd == BC_WARM);
        do_arm    = first_cyc && (cmd == BC_ARM);
        do_ident  = first_cyc && (cmd == BC_IDENT);
        do_unk    = first_cyc && (cmd == BC_UNKNOWN);
        do_load   = accept && in_win && load_armed && data_zero;
        step      = load_req && load_ack;
    end

    boot_addr_regs #(
        .DATA_W(DATA_W), .BLK_FIELD_W(BLK_FIELD_W), .BLK_W(BLK_W),
        .DENS_MASK(DENS_MASK), .PG_W(PG_W), .PG_STEP(4)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .clr(do_warm),
        .blk_we(accept && is_blk), .pg_we(accept && is_pg), .step(step),
        .wdata(wr_data), .block(cur_block), .page(cur_page), .sector(sector)
    );

    boot_id_seq #(.DATA_W(DATA_W), .N_WORDS(3)) u_id (
        .clk(clk), .rst_n(rst_n), .start(do_ident),
        .man(manuf_id), .dev(device_id), .wps(wp_state),
        .busy(id_busy), .idx(id_idx), .wdata(bbuf_wdata)
    );

    // Two-cycle load state: armed by the first write, cleared by the second.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_armed <= 1'b0;
        end else if (do_arm) begin
            load_armed <= 1'b1;
        end else if (accept && in_win) begin
            load_armed <= 1'b0;
        end
    end

    // Load request: captured sector held until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_req    <= 1'b0;
            load_sector <= '0;
        end else if (do_load) begin
            load_req    <= 1'b1;
            load_sector <= sector;
        end else if (step) begin
            load_req    <= 1'b0;
        end
    end

    // Warm-reset pulse and sticky unknown-command flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_rst <= 1'b0;
            unk_cmd  <= 1'b0;
        end else begin
            warm_rst <= do_warm;
            if (do_unk) unk_cmd <= 1'b1;
        end
    end

    // Port-side outputs.
    always_comb begin
        wr_stall = load_req || id_busy;
        bbuf_we  = id_busy;
        bbuf_idx = id_idx;
    end
endmodule

// File: rtl/boot_cmd_chk.sv
// Property checker for the boot-window interpreter, bound to the top.
module boot_cmd_chk #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned SEC_W  = 21
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_stall,
    input logic              load_req,
    input logic [SEC_W-1:0]  load_sector,
    input logic              load_ack,
    input logic              bbuf_we,
    input logic [1:0]        bbuf_idx,
    input logic              warm_rst,
    input logic              unk_cmd,
    input logic              load_armed,
    input logic [DATA_W-1:0] cur_block,
    input logic [7:0]        cur_page
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        load_req && !load_ack |=> load_req && $stable(load_sector)); // R5

    AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        load_req && load_ack |=> !load_req && (cur_page == 8'($past(cur_page) + 8'd4))); // R6

    AST_WARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst |-> cur_page == 8'd0 && cur_block == '0 && !load_armed); // R3

    AST_WARM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst |=> !warm_rst); // R3

    AST_UNK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        unk_cmd |=> unk_cmd); // R8

    AST_ID_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        bbuf_we && bbuf_idx != 2'd2 |=> bbuf_we && bbuf_idx == $past(bbuf_idx) + 2'd1); // R7

    AST_STALL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stall && wr_en && !load_ack |=>
            $stable(cur_page) && $stable(cur_block) && $stable(load_armed)); // R9
endmodule

bind boot_cmd_ctrl boot_cmd_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEC_W(SEC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_stall(wr_stall),
    .load_req(load_req), .load_sector(load_sector), .load_ack(load_ack),
    .bbuf_we(bbuf_we), .bbuf_idx(bbuf_idx), .warm_rst(warm_rst),
    .unk_cmd(unk_cmd), .load_armed(load_armed), .cur_block(cur_block),
    .cur_page(cur_page)
);

// File: tb/tb_boot_cmd_ctrl.sv
// Bench: behavioural reference model compared every clock, plus directed checks.
module tb_boot_cmd_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        load_ack = 1'b0;
    logic [15:0] manuf_id  = 16'hA5EC;
    logic [15:0] device_id = 16'h3C42;
    logic [15:0] wp_state  = 16'h0102;
    logic        wr_stall, load_req, bbuf_we, warm_rst, unk_cmd, load_armed;
    logic [20:0] load_sector;
    logic [1:0]  bbuf_idx;
    logic [15:0] bbuf_wdata, cur_block;
    logic [7:0]  cur_page;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    boot_cmd_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_stall(wr_stall), .manuf_id(manuf_id),
        .device_id(device_id), .wp_state(wp_state), .load_req(load_req),
        .load_sector(load_sector), .load_ack(load_ack), .bbuf_we(bbuf_we),
        .bbuf_idx(bbuf_idx), .bbuf_wdata(bbuf_wdata), .warm_rst(warm_rst),
        .unk_cmd(unk_cmd), .load_armed(load_armed), .cur_block(cur_block),
        .cur_page(cur_page)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model state.
    int m_armed, m_req, m_sec, m_page, m_block, m_unk, m_id, m_warm;

    function automatic bit in_window(input int a);
        return (a <= 'h01FF) || (a >= 'h8000 && a <= 'h800F);
    endfunction

    // Model update on each clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_armed = 0; m_req = 0; m_sec = 0; m_page = 0; m_block = 0;
            m_unk = 0; m_id = -1; m_warm = 0;
        end else begin
            automatic bit acc = wr_en && !(m_req != 0 || m_id >= 0);
            automatic int a = int'(wr_addr);
            automatic int d = int'(wr_data);
            m_warm = 0;
            if (m_id >= 0) m_id = (m_id == 2) ? -1 : m_id + 1;
            if (m_req != 0 && load_ack) begin
                m_req = 0;
                m_page = (m_page + 4) % 256;
            end
            if (acc) begin
                if (in_window(a)) begin
                    if (m_armed != 0) begin
                        m_armed = 0;
                        if (d == 0) begin
                            automatic int bn = m_block % 4096;
                            if (m_block >= 32768) bn = bn + 4096;
                            m_req = 1;
                            m_sec = bn * 256 + m_page;
                        end
                    end else if (d == 'h00F0) begin
                        m_warm = 1; m_page = 0; m_block = 0;
                    end else if (d == 'h00E0) m_armed = 1;
                    else if (d == 'h0090) m_id = 0;
                    else m_unk = 1;
                end else if (a == 'hC010) m_block = d;
                else if (a == 'hC011) m_page = d % 256;
            end
        end
    end

    // Compare every output against the model, away from the edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(load_req == (m_req != 0), "R5 load_req", load_req, m_req);
            if (m_req != 0) chk(int'(load_sector) == m_sec, "R5 load_sector", load_sector, m_sec);
            chk(int'(cur_page) == m_page, "R6 cur_page", cur_page, m_page);
            chk(int'(cur_block) == m_block, "R10 cur_block", cur_block, m_block);
            chk(warm_rst == (m_warm != 0), "R3 warm_rst", warm_rst, m_warm);
            chk(unk_cmd == (m_unk != 0), "R8 unk_cmd", unk_cmd, m_unk);
            chk(load_armed == (m_armed != 0), "R4 load_armed", load_armed, m_armed);
            chk(wr_stall == (m_req != 0 || m_id >= 0), "R9 wr_stall", wr_stall, m_req);
            chk(bbuf_we == (m_id >= 0), "R7 bbuf_we", bbuf_we, m_id >= 0);
            if (m_id >= 0) begin
                automatic int ev = (m_id == 0) ? manuf_id[7:0] :
                                   (m_id == 1) ? device_id[7:0] : wp_state[7:0];
                chk(int'(bbuf_idx) == m_id, "R7 bbuf_idx", bbuf_idx, m_id);
                chk(int'(bbuf_wdata) == ev, "R7 bbuf_wdata", bbuf_wdata, ev);
            end
        end
    end

    // One-cycle write; returns at the negedge after the edge that took it.
    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ack_once();
        @(negedge clk);
        load_ack = 1'b1;
        @(negedge clk);
        load_ack = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(!load_req && !bbuf_we && !wr_stall && !warm_rst && !unk_cmd && !load_armed,
            "R1 reset flags", {load_req, bbuf_we, wr_stall, warm_rst, unk_cmd, load_armed}, 0);
        chk(cur_block == 0 && cur_page == 0, "R1 reset regs", {cur_block, cur_page}, 0);

        // R10: address registers
        wr(16'hC010, 16'h0003);
        wr(16'hC011, 16'hAB05);
        chk(cur_block == 16'h0003, "R10 block", cur_block, 16'h0003);
        chk(cur_page == 8'h05, "R10 page", cur_page, 8'h05);

        // R4/R5: load sequence, second write in the upper window
        wr(16'h0000, 16'h00E0);
        chk(load_armed, "R4 armed", load_armed, 1);
        wr(16'h8004, 16'h0000);
        chk(load_req && load_sector == 21'h000305, "R5 sector", load_sector, 21'h000305);
        // R9: writes during a pending load are dropped
        wr(16'hC011, 16'h0077);
        wr(16'h0010, 16'h00F0);
        chk(cur_page == 8'h05 && !warm_rst, "R9 dropped", cur_page, 8'h05);
        chk(load_req && load_sector == 21'h000305, "R5 held", load_sector, 21'h000305);
        ack_once();
        chk(!load_req && cur_page == 8'h09, "R6 step", cur_page, 8'h09);

        // R6: page wrap at 8 bits
        wr(16'hC011, 16'h00FC);
        wr(16'h01FF, 16'h00E0);
        wr(16'h01FF, 16'h0000);
        idle(2);
        ack_once();
        chk(cur_page == 8'h00, "R6 wrap", cur_page, 8'h00);

        // R5: density mask merge; bits 14:12 ignored
        wr(16'hC010, 16'hF002);
        wr(16'hC011, 16'h0011);
        wr(16'h800F, 16'h00E0);
        wr(16'h0100, 16'h0000);
        chk(load_sector == 21'h100211, "R5 density", load_sector, 21'h100211);
        ack_once();

        // R4: consumed second cycle is not a command
        wr(16'h0000, 16'h00E0);
        wr(16'h0000, 16'h00F0);
        chk(!warm_rst && !load_armed && !load_req, "R4 consume F0", warm_rst, 0);
        wr(16'h0000, 16'h00E0);
        wr(16'h0002, 16'h1234);
        chk(!load_req && !load_armed && !unk_cmd, "R4 nonzero", load_req, 0);

        // R7: identification words
        wr(16'h0040, 16'h0090);
        chk(bbuf_we && bbuf_idx == 0 && bbuf_wdata == 16'h00EC, "R7 word0", bbuf_wdata, 16'h00EC);
        @(negedge clk);
        chk(bbuf_we && bbuf_idx == 1 && bbuf_wdata == 16'h0042, "R7 word1", bbuf_wdata, 16'h0042);
        @(negedge clk);
        chk(bbuf_we && bbuf_idx == 2 && bbuf_wdata == 16'h0002, "R7 word2", bbuf_wdata, 16'h0002);
        @(negedge clk);
        chk(!bbuf_we && !wr_stall, "R7 end", bbuf_we, 0);

        // R2: command values outside the windows
        wr(16'h0200, 16'h00F0);
        wr(16'h8010, 16'h0055);
        wr(16'h7FFF, 16'h00E0);
        chk(!warm_rst && !unk_cmd && !load_armed, "R2 outside", {warm_rst, unk_cmd, load_armed}, 0);

        // R8: unknown value, sticky
        wr(16'h8001, 16'h0055);
        chk(unk_cmd, "R8 set", unk_cmd, 1);
        idle(3);
        chk(unk_cmd, "R8 sticky", unk_cmd, 1);

        // R3: warm reset clears registers and arm
        wr(16'h0000, 16'h00E0);
        wr(16'h800F, 16'h00F0);
        chk(!warm_rst && !load_armed, "R3 consumed", warm_rst, 0);
        wr(16'h800F, 16'h00F0);
        chk(warm_rst && cur_block == 0 && cur_page == 0, "R3 pulse", cur_block, 0);
        @(negedge clk);
        chk(!warm_rst && unk_cmd, "R3 one cycle", warm_rst, 0);

        // R1: reset again clears the sticky flag
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        chk(!unk_cmd && !load_armed, "R1 re-reset", unk_cmd, 0);

        idle(2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule